// File: doc/BRIEF.md
# String Load Step Unit

This unit carries out a single step of a string load. A request brings an opcode byte, an operand-size code and the current source pointer. The unit works out the element width and issues one memory read of that width at the pointer. It returns the loaded element zero-extended to 64 bits, together with the source pointer moved by one element.

The pointer moves toward higher addresses when the direction flag is clear and toward lower addresses when it is set. The 64-bit element width is allowed only while the 64-bit-mode input is high. A request that asks for it outside that mode, or that carries any opcode other than the two string-load codes, ends with an invalid-opcode fault. In that case no read is issued and the pointer is not changed. The unit has no flag outputs, so it leaves all status flags as they were.

The unit takes one request at a time. The pointer update waits for the read data, so both results appear together with a one-cycle done pulse.

Top module: `strld_step`

## Requirements
- R1: After reset, req_ready is 1, and done, fault_ud, mem_req_valid, acc_out and ptr_out are all 0.
- R2: Opcode 0xAC selects a 1-byte element, and the read is issued with mem_size = 0 (log2 of the byte count).
- R3: Opcode 0xAD selects the element by req_osz: 00 gives 2 bytes (mem_size 1), 01 gives 4 bytes (mem_size 2), 10 or 11 gives 8 bytes (mem_size 3).
- R4: For a legal request accepted at clock edge N, mem_req_valid is high for exactly the cycle between edges N and N+1, with mem_addr equal to req_ptr. It is the only read for that request.
- R5: acc_out holds the low element-size bytes of mem_rdata and zeros above them.
- R6: With dir_flag = 0 the new pointer is req_ptr + bytes; with dir_flag = 1 it is req_ptr - bytes. The step is 1, 2, 4 or 8 bytes, matching the element.
- R7: The pointer arithmetic wraps modulo 2^64.
- R8: An 8-byte request while long_mode = 0 raises fault_ud together with done in the cycle after acceptance. It issues no read, gives ptr_out = req_ptr and gives acc_out = 0.
- R9: Any opcode other than 0xAC or 0xAD faults in the same way as R8.
- R10: done is a one-cycle pulse. A legal request raises it in the cycle after the edge that samples mem_rvalid high. req_ready is low from acceptance through the done cycle. acc_out and ptr_out hold their values until the next done.
- R11: dir_flag and long_mode are sampled at acceptance. Changing them while the read is pending has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle; request taken when both are high |
| req_opcode | input | 8 | Opcode byte |
| req_osz | input | 2 | Operand-size code (00=16, 01=32, 1x=64) |
| req_ptr | input | 64 | Current source pointer |
| dir_flag | input | 1 | Direction flag (1 = decrement) |
| long_mode | input | 1 | 64-bit mode active |
| mem_req_valid | output | 1 | Read request strobe |
| mem_addr | output | 64 | Read address |
| mem_size | output | 2 | log2 of the read width in bytes |
| mem_rdata | input | 64 | Read data, element in the low bytes |
| mem_rvalid | input | 1 | Read data valid |
| acc_out | output | 64 | Zero-extended loaded element |
| ptr_out | output | 64 | Updated source pointer |
| done | output | 1 | Step complete, results valid |
| fault_ud | output | 1 | Invalid-opcode fault, valid with done |

## Verification
The hardest case to reach from the ports is a change of the direction flag or the mode input after acceptance, while the read is still pending. The unit must return results built from the values it sampled, not the values present when the data returns. The sweep toggles both inputs right after acceptance on every other request and varies the read latency. It also covers every opcode class, size code, direction and mode against pointers at the wrap edges. Each fault case must produce no read strobe at all, and the bench confirms this with a read counter kept in its memory model.

// File: rtl/strld_pkg.sv
package strld_pkg;
  typedef enum logic [1:0] {ESZ_B = 2'd0, ESZ_W = 2'd1, ESZ_D = 2'd2, ESZ_Q = 2'd3} esz_t;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT, ST_RESP} st_t;

  // byte lane b is part of an element of size 2**e bytes
  function automatic logic lane_keep(input int unsigned b, input esz_t e);
    return (b >> e) == 0;
  endfunction
endpackage

// File: rtl/strld_decode.sv
module strld_decode
  import strld_pkg::*;
#(
  parameter logic [7:0] OPC_BYTE = 8'hAC,
  parameter logic [7:0] OPC_WIDE = 8'hAD
) (
  input  logic [7:0] opcode,
  input  logic [1:0] osz,
  input  logic       long_mode,
  output esz_t       esz,
  output logic       fault
);
  always_comb begin
    esz   = ESZ_B;
    fault = 1'b0;
    if (opcode == OPC_BYTE) begin
      esz = ESZ_B;
    end else if (opcode == OPC_WIDE) begin
      case (osz)
        2'b00:   esz = ESZ_W;
        2'b01:   esz = ESZ_D;
        default: begin
          esz   = ESZ_Q;
          fault = !long_mode;
        end
      endcase
    end else begin
      fault = 1'b1;
    end
  end
endmodule

// File: rtl/strld_ptr.sv
module strld_ptr
  import strld_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [AW-1:0] ptr,
  input  esz_t          esz,
  input  logic          dir,
  output logic [AW-1:0] nxt_ptr
);
  function automatic logic [AW-1:0] step_of(input esz_t e);
    return AW'(1) << e;
  endfunction

  assign nxt_ptr = dir ? (ptr - step_of(esz)) : (ptr + step_of(esz));
endmodule

// File: rtl/strld_pad.sv
module strld_pad
  import strld_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] rdata,
  input  esz_t          esz,
  output logic [DW-1:0] padded
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign padded[8*b +: 8] = lane_keep(b, esz) ? rdata[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/strld_ctrl.sv
module strld_ctrl
  import strld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic dec_fault,
  input  logic mem_rvalid,
  output logic req_ready,
  output logic accept,
  output logic fault_take,
  output logic mem_req_valid,
  output logic capture,
  output logic done
);
  st_t state, state_nxt;

  assign req_ready     = (state == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign fault_take    = accept && dec_fault;
  assign mem_req_valid = (state == ST_READ);
  assign capture       = (state == ST_WAIT) && mem_rvalid;
  assign done          = (state == ST_RESP);

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: if (accept) state_nxt = dec_fault ? ST_RESP : ST_READ;
      ST_READ: state_nxt = ST_WAIT;
      ST_WAIT: if (mem_rvalid) state_nxt = ST_RESP;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  // R4
  read_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_fault) |=> mem_req_valid);
  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  // R8
  fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (done && !mem_req_valid));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (done && !req_ready));
endmodule

// File: rtl/strld_step.sv
module strld_step
  import strld_pkg::*;
#(
  parameter int         AW       = 64,
  parameter int         DW       = 64,
  parameter logic [7:0] OPC_BYTE = 8'hAC,
  parameter logic [7:0] OPC_WIDE = 8'hAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [7:0]    req_opcode,
  input  logic [1:0]    req_osz,
  input  logic [AW-1:0] req_ptr,
  input  logic          dir_flag,
  input  logic          long_mode,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rvalid,
  output logic [DW-1:0] acc_out,
  output logic [AW-1:0] ptr_out,
  output logic          done,
  output logic          fault_ud
);
  esz_t          dec_esz;
  logic          dec_fault;
  logic          accept, fault_take, capture;
  esz_t          lat_esz;
  logic          lat_dir;
  logic [AW-1:0] lat_ptr;
  logic [AW-1:0] nxt_ptr;
  logic [DW-1:0] padded;
  logic [DW-1:0] acc_q;
  logic [AW-1:0] ptr_q;
  logic          flt_q;

  strld_decode #(.OPC_BYTE(OPC_BYTE), .OPC_WIDE(OPC_WIDE)) u_dec (
    .opcode(req_opcode), .osz(req_osz), .long_mode(long_mode),
    .esz(dec_esz), .fault(dec_fault)
  );

  strld_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dec_fault(dec_fault),
    .mem_rvalid(mem_rvalid), .req_ready(req_ready), .accept(accept),
    .fault_take(fault_take), .mem_req_valid(mem_req_valid),
    .capture(capture), .done(done)
  );

  strld_ptr #(.AW(AW)) u_ptr (
    .ptr(lat_ptr), .esz(lat_esz), .dir(lat_dir), .nxt_ptr(nxt_ptr)
  );

  strld_pad #(.DW(DW)) u_pad (
    .rdata(mem_rdata), .esz(lat_esz), .padded(padded)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_esz <= ESZ_B;
      lat_dir <= 1'b0;
      lat_ptr <= '0;
    end else if (accept) begin
      lat_esz <= dec_esz;
      lat_dir <= dir_flag;
      lat_ptr <= req_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ptr_q <= '0;
      flt_q <= 1'b0;
    end else if (fault_take) begin
      acc_q <= '0;
      ptr_q <= req_ptr;
      flt_q <= 1'b1;
    end else if (capture) begin
      acc_q <= padded;
      ptr_q <= nxt_ptr;
      flt_q <= 1'b0;
    end
  end

  assign mem_addr = lat_ptr;
  assign mem_size = lat_esz;
  assign acc_out  = acc_q;
  assign ptr_out  = ptr_q;
  assign fault_ud = done && flt_q;

  // R8
  fault_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (fault_ud && ptr_out == $past(req_ptr) && acc_out == '0));
  // R6
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault_ud) |->
      ((lat_dir ? (lat_ptr - ptr_out) : (ptr_out - lat_ptr)) == (AW'(1) << lat_esz)));
  // R5
  zero_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((acc_out >> (32'd8 << lat_esz)) == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_take && !capture) |=> ($stable(acc_out) && $stable(ptr_out)));
endmodule

// File: tb/sim_strld_step.sv
module sim_strld_step;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = '0;
  logic [1:0]  req_osz = '0;
  logic [63:0] req_ptr = '0;
  logic        dir_flag = 1'b0;
  logic        long_mode = 1'b0;
  logic        mem_req_valid;
  logic [63:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic [63:0] acc_out;
  logic [63:0] ptr_out;
  logic        done;
  logic        fault_ud;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int mem_lat = 1;
  logic [63:0] rd_addr;
  logic [1:0]  rd_size;
  bit finished = 0;

  always #4 clk = ~clk;

  strld_step u0 (.*);

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {~a[31:0], a[31:0] ^ 32'h5A3C_96E1};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one outstanding read
  initial forever begin
    @(negedge clk);
    if (mem_req_valid) begin
      reads++;
      rd_addr = mem_addr;
      rd_size = mem_size;
      repeat (mem_lat) @(negedge clk);
      mem_rdata  = mem_word(rd_addr);
      mem_rvalid = 1'b1;
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_rdata  = 64'hDEAD_BEEF_DEAD_BEEF;
    end
  end

  task automatic do_op(input logic [7:0] opc, input logic [1:0] osz, input logic dir,
                       input logic lm, input logic [63:0] ptr, input int lat, input bit flip);
    int nbytes;
    int lg;
    bit flt;
    int r0;
    int n;
    logic [63:0] mask, e_acc, e_ptr, s_acc, s_ptr;
    flt = 0; nbytes = 1; lg = 0;
    if (opc == 8'hAC) begin nbytes = 1; lg = 0; end
    else if (opc == 8'hAD) begin
      if (osz == 2'b00) begin nbytes = 2; lg = 1; end
      else if (osz == 2'b01) begin nbytes = 4; lg = 2; end
      else begin nbytes = 8; lg = 3; flt = !lm; end
    end else flt = 1;
    mem_lat = lat;
    r0 = reads;
    @(negedge clk);
    req_valid = 1; req_opcode = opc; req_osz = osz; req_ptr = ptr;
    dir_flag = dir; long_mode = lm;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    req_ptr = ~ptr;
    if (flip) begin dir_flag = ~dir; long_mode = ~lm; end
    chk("R10 ready low while busy", {63'd0, req_ready}, 64'd0);
    n = 0;
    while (!done && n < 64) begin @(negedge clk); n++; end
    mask  = (nbytes == 8) ? '1 : ((64'd1 << (8*nbytes)) - 1);
    e_acc = flt ? 64'd0 : (mem_word(ptr) & mask);
    e_ptr = flt ? ptr : (dir ? ptr - 64'(nbytes) : ptr + 64'(nbytes));
    chk("R10 done seen", {63'd0, done}, 64'd1);
    if (opc != 8'hAC && opc != 8'hAD) chk("R9 fault on foreign opcode", {63'd0, fault_ud}, 64'd1);
    else chk("R8 fault flag", {63'd0, fault_ud}, {63'd0, flt});
    chk(flip ? "R11 acc with inputs changed" : "R5 acc zero-extended", acc_out, e_acc);
    chk(flip ? "R11 ptr with inputs changed" : "R6 R7 pointer step", ptr_out, e_ptr);
    chk("R4 read count", 64'(reads - r0), flt ? 64'd0 : 64'd1);
    if (!flt) begin
      chk("R4 read address", rd_addr, ptr);
      chk(opc == 8'hAC ? "R2 byte size" : "R3 size code", {62'd0, rd_size}, 64'(lg));
    end else begin
      chk("R8 fault done next cycle", 64'(n), 64'd0);
    end
    s_acc = acc_out; s_ptr = ptr_out;
    @(negedge clk);
    chk("R10 done one pulse", {63'd0, done}, 64'd0);
    chk("R10 ready back", {63'd0, req_ready}, 64'd1);
    chk("R10 acc held", acc_out, s_acc);
    chk("R10 ptr held", ptr_out, s_ptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] ptrs [5];
    logic [7:0]  opcs [4];
    int idx;
    ptrs[0] = 64'd0; ptrs[1] = 64'd1; ptrs[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    ptrs[3] = 64'h0000_0000_FFFF_FFFE; ptrs[4] = 64'h1234_5678_9ABC_DEF0;
    opcs[0] = 8'hAC; opcs[1] = 8'hAD; opcs[2] = 8'hAE; opcs[3] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ready", {63'd0, req_ready}, 64'd1);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 fault", {63'd0, fault_ud}, 64'd0);
    chk("R1 mem strobe", {63'd0, mem_req_valid}, 64'd0);
    chk("R1 acc", acc_out, 64'd0);
    chk("R1 ptr", ptr_out, 64'd0);
    rst_n = 1'b1;
    idx = 0;
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 2; d++)
          for (int m = 0; m < 2; m++)
            for (int p = 0; p < 5; p++) begin
              do_op(opcs[o], 2'(s), 1'(d), 1'(m), ptrs[p], (idx % 3) + 1, idx[0]);
              idx++;
            end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule